// File: doc/BRIEF.md
# Receive Self-Test Status Checker

This block sits behind a receive decoder and checks a built-in self-test stream. While the test is enabled and the receive clock is locked, it hunts for a start-of-test marker character. After the marker it compares every valid character with the output of an internal linear-feedback shift register that runs the same pattern as the far-end generator. Every clock it publishes a registered 3-bit status code. The code tells apart idle or unlocked, hunting, per-character pass, per-character mismatch, and a good or bad final character of the pattern.

The pattern is `SEQ_LEN` characters long. After the final character the generator reloads its seed and comparing carries on without a new marker. A loss of lock at any time sends the checker back to its start code, and it must find the marker again before it compares anything. Characters with the valid flag low are ignored.

Top module: `rx_bist_status`

## Requirements
- R1: While reset is asserted, and on every clock edge where `bistEn` is low, the status becomes 101 (start).
- R2: A clock edge with `pllLock` low gives status 101. After lock returns, the checker reports 111 and compares nothing, even a character equal to the expected pattern, until it has seen the marker again.
- R3: The first enabled and locked edge after start gives 111. Status stays 111 while the checker hunts. The edge that accepts the marker (default 8'h3C) also gives 111.
- R4: After the marker, the k-th valid character (k = 0, 1, ...) is compared with LFSR state k. State 0 is the seed 8'h01, and each next state is `{s[6:0], ^(s & 8'hB8)}`.
- R5: Matching characters that are not the last one report 000 and 001 in turn. The first pass after a marker is 000.
- R6: A non-final character that differs in any bit reports 110. It does not advance the 000/001 alternation.
- R7: Character index `SEQ_LEN-1` reports 010 if it matches and 100 if it does not.
- R8: After the final character the pattern restarts at the seed and comparison continues with no new marker.
- R9: The status code 011 is never produced.
- R10: A cycle with `charValid` low leaves the status and the pattern position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low synchronous reset |
| charIn | input | CHAR_W | Decoded received character |
| charValid | input | 1 | `charIn` holds a character this cycle |
| bistEn | input | 1 | Self-test checking enabled |
| pllLock | input | 1 | Receive clock recovery locked |
| bistStatus | output | 3 | Registered status code |

## Verification
On every cycle the embedded assertions check four things. Loss of lock or enable forces the start code. Start is always followed by hunting. The reserved code never appears. The generator is at its seed and index zero after a marker or a final character. Whether each comparison uses the right pattern value, whether the 000/001 alternation survives mismatches and wraps, and whether the final-position verdict is correct can only be shown by the bench. The bench sweeps a corrupted character across every position of the pattern and checks each status code against an arithmetic model of the generator.

// File: rtl/rx_bist_pkg.sv
`timescale 1ns/1ps
package rx_bist_pkg;
  localparam logic [2:0] ST_PASS0    = 3'b000;
  localparam logic [2:0] ST_PASS1    = 3'b001;
  localparam logic [2:0] ST_LASTGOOD = 3'b010;
  localparam logic [2:0] ST_RSVD     = 3'b011;
  localparam logic [2:0] ST_LASTBAD  = 3'b100;
  localparam logic [2:0] ST_START    = 3'b101;
  localparam logic [2:0] ST_ERR      = 3'b110;
  localparam logic [2:0] ST_WAIT     = 3'b111;

  typedef enum logic [1:0] {PH_START, PH_WAIT, PH_CMP} phase_t;

  typedef struct packed {
    logic loadSeed;
    logic advance;
  } bistStrobe_t;
endpackage

// File: rtl/rx_bist_datapath.sv
`timescale 1ns/1ps
module rx_bist_datapath
  import rx_bist_pkg::*;
#(
  parameter int          CHAR_W  = 8,
  parameter int          SEQ_LEN = 16,
  parameter logic [CHAR_W-1:0] SEED = 8'h01,
  parameter logic [CHAR_W-1:0] TAPS = 8'hB8,
  parameter logic [CHAR_W-1:0] MARK = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] charIn,
  input  bistStrobe_t       strobe,
  output logic              isMarker,
  output logic              isMatch,
  output logic              isLast
);
  localparam int IDX_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

  logic [CHAR_W-1:0] lfsr;
  logic [CHAR_W-1:0] lfsrNext;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    lfsrNext = {lfsr[CHAR_W-2:0], ^(lfsr & TAPS)};
    isMarker = (charIn == MARK);
    isMatch  = (charIn == lfsr);
    isLast   = (idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr <= SEED;
      idx  <= '0;
    end else if (strobe.loadSeed || (strobe.advance && isLast)) begin
      lfsr <= SEED;
      idx  <= '0;
    end else if (strobe.advance) begin
      lfsr <= lfsrNext;
      idx  <= idx + 1'b1;
    end
  end

  assert_seed_after_marker_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSeed |=> (lfsr == SEED && idx == '0));
  assert_wrap_to_seed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && isLast) |=> (lfsr == SEED && idx == '0));
  assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.advance || strobe.loadSeed) |=> $stable(lfsr));
endmodule

// File: rtl/rx_bist_control.sv
`timescale 1ns/1ps
module rx_bist_control
  import rx_bist_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        charValid,
  input  logic        bistEn,
  input  logic        pllLock,
  input  logic        isMarker,
  input  logic        isMatch,
  input  logic        isLast,
  output bistStrobe_t strobe,
  output logic [2:0]  bistStatus
);
  phase_t phase;
  logic   passTog;
  logic   running;

  always_comb begin
    running         = bistEn && pllLock;
    strobe.loadSeed = running && (phase == PH_WAIT) && charValid && isMarker;
    strobe.advance  = running && (phase == PH_CMP) && charValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_START;
      bistStatus <= ST_START;
      passTog    <= 1'b0;
    end else if (!running) begin
      phase      <= PH_START;
      bistStatus <= ST_START;
    end else begin
      case (phase)
        PH_START: begin
          phase      <= PH_WAIT;
          bistStatus <= ST_WAIT;
        end
        PH_WAIT: begin
          bistStatus <= ST_WAIT;
          if (strobe.loadSeed) begin
            phase   <= PH_CMP;
            passTog <= 1'b0;
          end
        end
        PH_CMP: begin
          if (strobe.advance) begin
            if (isLast) begin
              bistStatus <= isMatch ? ST_LASTGOOD : ST_LASTBAD;
            end else if (isMatch) begin
              bistStatus <= {2'b00, passTog};
              passTog    <= ~passTog;
            end else begin
              bistStatus <= ST_ERR;
            end
          end
        end
        default: begin
          phase      <= PH_START;
          bistStatus <= ST_START;
        end
      endcase
    end
  end

  assert_no_reserved_R9: assert property (@(posedge clk) disable iff (!rstN)
    bistStatus != ST_RSVD);
  assert_unlock_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pllLock |=> bistStatus == ST_START);
  assert_disable_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    !bistEn |=> bistStatus == ST_START);
  assert_start_then_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    (bistStatus == ST_START && running) |=> bistStatus == ST_WAIT);
  assert_first_pass_even_R5: assert property (@(posedge clk) disable iff (!rstN)
    bistStatus == ST_WAIT |=> bistStatus != ST_PASS1);
endmodule

// File: rtl/rx_bist_status.sv
`timescale 1ns/1ps
module rx_bist_status
  import rx_bist_pkg::*;
#(
  parameter int          CHAR_W  = 8,
  parameter int          SEQ_LEN = 16,
  parameter logic [CHAR_W-1:0] SEED = 8'h01,
  parameter logic [CHAR_W-1:0] TAPS = 8'hB8,
  parameter logic [CHAR_W-1:0] MARK = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] charIn,
  input  logic              charValid,
  input  logic              bistEn,
  input  logic              pllLock,
  output logic [2:0]        bistStatus
);
  bistStrobe_t strobe;
  logic isMarker, isMatch, isLast;

  rx_bist_datapath #(
    .CHAR_W(CHAR_W), .SEQ_LEN(SEQ_LEN), .SEED(SEED), .TAPS(TAPS), .MARK(MARK)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .charIn(charIn), .strobe(strobe),
    .isMarker(isMarker), .isMatch(isMatch), .isLast(isLast)
  );

  rx_bist_control uControl (
    .clk(clk), .rstN(rstN), .charValid(charValid), .bistEn(bistEn),
    .pllLock(pllLock), .isMarker(isMarker), .isMatch(isMatch),
    .isLast(isLast), .strobe(strobe), .bistStatus(bistStatus)
  );
endmodule

// File: tb/tb_rx_bist_status.sv
`timescale 1ns/1ps
module tb_rx_bist_status;
  localparam int        SL   = 16;
  localparam logic [7:0] SEED = 8'h01;
  localparam logic [7:0] TAPS = 8'hB8;
  localparam logic [7:0] MARK = 8'h3C;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN, charValid, bistEn, pllLock;
  logic [7:0] charIn;
  logic [2:0] bistStatus;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mLfsr;
  int         mIdx;
  logic       mTog;
  logic [2:0] lastSeen;

  rx_bist_status dut (
    .clk(clk), .rstN(rstN), .charIn(charIn), .charValid(charValid),
    .bistEn(bistEn), .pllLock(pllLock), .bistStatus(bistStatus)
  );

  function automatic logic [7:0] nextL(input logic [7:0] s);
    return {s[6:0], ^(s & TAPS)};
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if (bistStatus !== exp) begin
      errors++;
      $display("FAIL %s status=%03b expected=%03b", req, bistStatus, exp);
    end
    checks++;
    if (bistStatus === 3'b011) begin
      errors++;
      $display("FAIL R9 status=%03b expected=not 011", bistStatus);
    end
  endtask

  task automatic cyc(input logic [7:0] ch, input logic v);
    @(negedge clk);
    charIn = ch;
    charValid = v;
    @(posedge clk);
    #1;
  endtask

  task automatic markerSeen();
    mLfsr = SEED; mIdx = 0; mTog = 1'b0;
  endtask

  task automatic sendExp(input bit corrupt, input string req);
    logic [2:0] exp;
    bit last;
    cyc(mLfsr ^ (corrupt ? 8'h01 : 8'h00), 1'b1);
    last = (mIdx == SL - 1);
    if (last) exp = corrupt ? 3'b100 : 3'b010;
    else if (corrupt) exp = 3'b110;
    else begin exp = {2'b00, mTog}; mTog = ~mTog; end
    check(req, exp);
    lastSeen = exp;
    if (last) begin mLfsr = SEED; mIdx = 0; end
    else begin mLfsr = nextL(mLfsr); mIdx++; end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; bistEn = 1'b0; pllLock = 1'b1; charIn = '0; charValid = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", 3'b101);
    @(negedge clk) rstN = 1'b1;
    cyc(MARK, 1'b1);  check("R1 disabled", 3'b101);
    cyc(8'h00, 1'b0); check("R1 disabled", 3'b101);
    @(negedge clk) bistEn = 1'b1;
    cyc(8'h00, 1'b0); check("R3 enter wait", 3'b111);
    cyc(8'h55, 1'b1); check("R3 hunting", 3'b111);
    cyc(SEED, 1'b1);  check("R3 hunting", 3'b111);
    cyc(8'h00, 1'b0); check("R3 hunting", 3'b111);
    cyc(MARK, 1'b1);  check("R3 marker", 3'b111);
    markerSeen();
    for (int i = 0; i < SL; i++) sendExp(1'b0, "R4 R5 R7 clean pass");
    for (int p = 0; p < SL; p++)
      for (int i = 0; i < SL; i++)
        sendExp(i == p, (p == SL - 1) ? "R7 R8 sweep" : "R6 R8 sweep");
    for (int i = 0; i < 5; i++) begin
      sendExp(1'b0, "R10 before gap");
      cyc(~mLfsr, 1'b0); check("R10 gap holds", lastSeen);
    end
    sendExp(1'b0, "R10 after gap");
    @(negedge clk) pllLock = 1'b0;
    cyc(mLfsr, 1'b1); check("R2 lock lost", 3'b101);
    cyc(mLfsr, 1'b1); check("R2 lock lost", 3'b101);
    @(negedge clk) pllLock = 1'b1;
    cyc(8'h00, 1'b0); check("R2 relock wait", 3'b111);
    cyc(SEED, 1'b1);  check("R2 no compare before marker", 3'b111);
    cyc(MARK, 1'b1);  check("R2 marker", 3'b111);
    markerSeen();
    for (int i = 0; i < 3; i++) sendExp(1'b0, "R2 R5 resumed");
    @(negedge clk) bistEn = 1'b0;
    cyc(mLfsr, 1'b1); check("R1 disable mid-run", 3'b101);
    done = 1;
    finishRun();
  end
endmodule